// File: doc/BRIEF.md
# Mixer Control Register Bank

This block is the control store on the codec side of a serial audio link. The link's framing logic turns slot traffic into a plain command port: a 7-bit byte address, 16-bit write data, a write strobe and a read strobe. The block returns read data on a registered output. It holds the mixer settings: five stereo volume registers (master, line, CD, AUX, PCM), two mono volume registers (phone, mic), record source select, record gain, a general-purpose word carrying the 3D enable, 3D depth and the power-down request byte. It also answers a few read-only identity words.

Writes are normalised before they are stored. Every 6-bit volume code whose top bit is set is saturated to the 5-bit maximum. Bits that have no storage read back as zero. A write to location 00h returns all writable state to its defaults. The stored fields go straight to the analog and power control logic through dedicated outputs, so no decoding is needed elsewhere.

Top module: `mix_regfile`

## Requirements
- R1: After rst_ni is released, reads return 8000h for master (02h), 8808h for line (10h), CD (12h), AUX (16h) and PCM (18h), 8008h for phone (0Ch) and mic (0Eh), 8000h for record gain (1Ch), and 0000h for record select (1Ah), general (20h), 3D (22h) and the request byte of power-down (26h). All stereo mute outputs are high.
- R2: A stereo volume write stores bits 13:8 as the left field and bits 5:0 as the right field. A mono write stores bits 5:0. Any 6-bit code whose bit 5 is set is stored and read back as 1Fh.
- R3: Unstored bits read 0. Stereo volume keeps 15, 12:8 and 4:0. Mono keeps 15 and 4:0. Record select keeps 10:8 (left) and 2:0 (right). Record gain keeps 15, 11:8 and 3:0. General keeps only bit 13. 3D keeps only bits 1:0.
- R4: rdata_o takes the addressed value on the clock edge where rd_en_i is high, and holds it while rd_en_i is low. A read issued in the cycle after a write returns the written value.
- R5: A write of any data to 00h restores every writable register to its R1 value on the next edge. A read of 00h returns the parameter CAP_WORD (default 0400h).
- R6: Odd addresses and unmapped even addresses ignore writes and read as 0000h.
- R7: 28h reads 0600h (revision field 11:10 = 01, bit 9 = 1, bit 0 = 0). 7Ch reads 414Ch. 7Eh reads 4730h. Writes to these addresses are ignored.
- R8: At 26h, bits 15:8 are writable request bits and drive pd_req_o. Bits 3:0 return pd_status_i as sampled on the read edge. Bits 7:4 read 0.
- R9: spatial_en_o equals bit 13 of 20h. depth_o equals bits 1:0 of 22h when spatial_en_o is high, and 00 otherwise.
- R10: The exported fields equal the stored fields. Stereo slot i (0 master, 1 line, 2 CD, 3 AUX, 4 PCM) drives st_mute_o[i], st_left_o[5i+4:5i] and st_right_o[5i+4:5i]. Mono slot j (0 phone, 1 mic) drives mono_mute_o[j] and mono_vol_o[5j+4:5j]. The record select codes 0 to 7 pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Byte address of the register |
| wdata_i | input | 16 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| pd_status_i | input | PSW (4) | Ready/status flags shown at 26h bits 3:0 |
| st_mute_o | output | 5 | Stereo mute per slot |
| st_left_o | output | 25 | Stereo left volume codes, 5 bits per slot |
| st_right_o | output | 25 | Stereo right volume codes, 5 bits per slot |
| mono_mute_o | output | 2 | Mono mute per slot |
| mono_vol_o | output | 10 | Mono volume codes, 5 bits per slot |
| rec_sel_l_o | output | 3 | Left record source code |
| rec_sel_r_o | output | 3 | Right record source code |
| rec_mute_o | output | 1 | Record gain mute |
| rec_gain_l_o | output | 4 | Left record gain |
| rec_gain_r_o | output | 4 | Right record gain |
| spatial_en_o | output | 1 | 3D enable |
| depth_o | output | 2 | Effective 3D depth |
| pd_req_o | output | 8 | Power-down request bits |

## Verification
Every stored field and every exported output changes on the edge that samples the write strobe. The bench therefore drives each command at a falling edge, releases it one cycle later and samples at that falling edge. rdata_o is one register deep, so a read's result is checked at the falling edge that follows the sampling edge. A read placed right after a write sees the new value. The status nibble at 26h is held steady across the read edge. The idle check samples rdata_o over several cycles with no strobe and expects no change.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int DW   = 16;
  localparam int AW   = 7;
  localparam int VW   = 5;
  localparam int N_ST = 5;
  localparam int N_MO = 2;
  localparam int N_CT = 5;

  localparam logic [AW-1:0] A_RESET = 7'h00;
  localparam logic [AW-1:0] A_EXTID = 7'h28;
  localparam logic [AW-1:0] A_VID1  = 7'h7C;
  localparam logic [AW-1:0] A_VID2  = 7'h7E;

  localparam logic [AW-1:0] ST_ADDR [N_ST] = '{7'h02, 7'h10, 7'h12, 7'h16, 7'h18};
  localparam logic [DW-1:0] ST_RST  [N_ST] = '{16'h8000, 16'h8808, 16'h8808, 16'h8808, 16'h8808};
  localparam logic [AW-1:0] MO_ADDR [N_MO] = '{7'h0C, 7'h0E};
  localparam logic [DW-1:0] MO_RST  [N_MO] = '{16'h8008, 16'h8008};

  // control slots: record select, record gain, general, 3D, power-down
  localparam int C_RSEL  = 0;
  localparam int C_RGAIN = 1;
  localparam int C_GP    = 2;
  localparam int C_3D    = 3;
  localparam int C_PD    = 4;
  localparam logic [AW-1:0] CT_ADDR [N_CT] = '{7'h1A, 7'h1C, 7'h20, 7'h22, 7'h26};
  localparam logic [DW-1:0] CT_MASK [N_CT] = '{16'h0707, 16'h8F0F, 16'h2000, 16'h0003, 16'hFF00};
  localparam logic [DW-1:0] CT_RST  [N_CT] = '{16'h0000, 16'h8000, 16'h0000, 16'h0000, 16'h0000};

  localparam logic [DW-1:0] EXTID_VAL = 16'h0600;
  localparam logic [DW-1:0] VID1_VAL  = 16'h414C;
  localparam logic [DW-1:0] VID2_VAL  = 16'h4730;

  function automatic logic [VW-1:0] sat_code(input logic [VW:0] v);
    return v[VW] ? {VW{1'b1}} : v[VW-1:0];
  endfunction
endpackage

// File: rtl/mix_vol_reg.sv
module mix_vol_reg
  import mix_pkg::*;
#(
  parameter bit            STEREO  = 1'b1,
  parameter logic [DW-1:0] RST_VAL = 16'h8808
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] nxt;
  logic          unused_rsv;

  assign unused_rsv = ^{wdata_i[14], wdata_i[7:6]};

  always_comb begin
    nxt          = '0;
    nxt[15]      = wdata_i[15];
    nxt[VW-1:0]  = sat_code(wdata_i[VW:0]);
    if (STEREO) nxt[8+:VW] = sat_code(wdata_i[8+:VW+1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (clr_i) q_o <= RST_VAL;
    else if (we_i)  q_o <= nxt;
  end

  p_sat_right_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !clr_i && wdata_i[VW] |=> q_o[VW-1:0] == {VW{1'b1}});

  if (STEREO) begin : g_left_chk
    p_sat_left_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && !clr_i && wdata_i[8+VW] |=> q_o[8+:VW] == {VW{1'b1}});
  end

  p_soft_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> q_o == RST_VAL);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && !clr_i |=> $stable(q_o));
endmodule

// File: rtl/mix_ctl_regs.sv
module mix_ctl_regs
  import mix_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic [N_CT-1:0]          we_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [N_CT-1:0][DW-1:0]  q_o
);
  for (genvar k = 0; k < N_CT; k++) begin : g_ct
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_o[k] <= CT_RST[k];
      else if (clr_i)   q_o[k] <= CT_RST[k];
      else if (we_i[k]) q_o[k] <= wdata_i & CT_MASK[k];
    end

    p_ct_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> q_o[k] == CT_RST[k]);
  end

  p_one_we_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_i));
endmodule

// File: rtl/mix_rd_mux.sv
module mix_rd_mux
  import mix_pkg::*;
#(
  parameter logic [DW-1:0] CAP_WORD = 16'h0400,
  parameter int            PSW      = 4
) (
  input  logic [AW-1:0]            addr_i,
  input  logic [N_ST-1:0][DW-1:0]  st_q_i,
  input  logic [N_MO-1:0][DW-1:0]  mo_q_i,
  input  logic [N_CT-1:0][DW-1:0]  ct_q_i,
  input  logic [PSW-1:0]           pd_status_i,
  output logic [DW-1:0]            rd_val_o
);
  localparam int PAD = 8 - PSW;

  logic [DW-1:0] pd_word;
  assign pd_word = {ct_q_i[C_PD][15:8], {PAD{1'b0}}, pd_status_i};

  always_comb begin
    rd_val_o = '0;
    for (int i = 0; i < N_ST; i++)
      if (addr_i == ST_ADDR[i]) rd_val_o = st_q_i[i];
    for (int j = 0; j < N_MO; j++)
      if (addr_i == MO_ADDR[j]) rd_val_o = mo_q_i[j];
    for (int k = 0; k < N_CT; k++)
      if (addr_i == CT_ADDR[k]) rd_val_o = (k == C_PD) ? pd_word : ct_q_i[k];
    case (addr_i)
      A_RESET: rd_val_o = CAP_WORD;
      A_EXTID: rd_val_o = EXTID_VAL;
      A_VID1:  rd_val_o = VID1_VAL;
      A_VID2:  rd_val_o = VID2_VAL;
      default: ;
    endcase
  end
endmodule

// File: rtl/mix_regfile.sv
module mix_regfile
  import mix_pkg::*;
#(
  parameter logic [15:0] CAP_WORD = 16'h0400,
  parameter int          PSW      = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [6:0]           addr_i,
  input  logic [15:0]          wdata_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  output logic [15:0]          rdata_o,
  input  logic [PSW-1:0]       pd_status_i,
  output logic [4:0]           st_mute_o,
  output logic [24:0]          st_left_o,
  output logic [24:0]          st_right_o,
  output logic [1:0]           mono_mute_o,
  output logic [9:0]           mono_vol_o,
  output logic [2:0]           rec_sel_l_o,
  output logic [2:0]           rec_sel_r_o,
  output logic                 rec_mute_o,
  output logic [3:0]           rec_gain_l_o,
  output logic [3:0]           rec_gain_r_o,
  output logic                 spatial_en_o,
  output logic [1:0]           depth_o,
  output logic [7:0]           pd_req_o
);
  logic                    wr_even;
  logic                    soft_clr;
  logic [N_ST-1:0]         st_we;
  logic [N_MO-1:0]         mo_we;
  logic [N_CT-1:0]         ct_we;
  logic [N_ST-1:0][DW-1:0] st_q;
  logic [N_MO-1:0][DW-1:0] mo_q;
  logic [N_CT-1:0][DW-1:0] ct_q;
  logic [DW-1:0]           rd_val;

  assign wr_even  = wr_en_i && !addr_i[0];
  assign soft_clr = wr_en_i && (addr_i == A_RESET);

  for (genvar i = 0; i < N_ST; i++) begin : g_st
    assign st_we[i] = wr_even && (addr_i == ST_ADDR[i]);
    mix_vol_reg #(.STEREO(1'b1), .RST_VAL(ST_RST[i])) u_vol (
      .clk_i, .rst_ni, .clr_i(soft_clr), .we_i(st_we[i]),
      .wdata_i, .q_o(st_q[i])
    );
    assign st_mute_o[i]         = st_q[i][15];
    assign st_left_o[i*VW+:VW]  = st_q[i][8+:VW];
    assign st_right_o[i*VW+:VW] = st_q[i][0+:VW];
  end

  for (genvar j = 0; j < N_MO; j++) begin : g_mo
    assign mo_we[j] = wr_even && (addr_i == MO_ADDR[j]);
    mix_vol_reg #(.STEREO(1'b0), .RST_VAL(MO_RST[j])) u_vol (
      .clk_i, .rst_ni, .clr_i(soft_clr), .we_i(mo_we[j]),
      .wdata_i, .q_o(mo_q[j])
    );
    assign mono_mute_o[j]        = mo_q[j][15];
    assign mono_vol_o[j*VW+:VW]  = mo_q[j][0+:VW];
  end

  for (genvar k = 0; k < N_CT; k++) begin : g_ctwe
    assign ct_we[k] = wr_even && (addr_i == CT_ADDR[k]);
  end

  mix_ctl_regs u_ctl (
    .clk_i, .rst_ni, .clr_i(soft_clr), .we_i(ct_we), .wdata_i, .q_o(ct_q)
  );

  mix_rd_mux #(.CAP_WORD(CAP_WORD), .PSW(PSW)) u_mux (
    .addr_i, .st_q_i(st_q), .mo_q_i(mo_q), .ct_q_i(ct_q),
    .pd_status_i, .rd_val_o(rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  assign rec_sel_l_o  = ct_q[C_RSEL][10:8];
  assign rec_sel_r_o  = ct_q[C_RSEL][2:0];
  assign rec_mute_o   = ct_q[C_RGAIN][15];
  assign rec_gain_l_o = ct_q[C_RGAIN][11:8];
  assign rec_gain_r_o = ct_q[C_RGAIN][3:0];
  assign spatial_en_o = ct_q[C_GP][13];
  assign depth_o      = spatial_en_o ? ct_q[C_3D][1:0] : 2'b00;
  assign pd_req_o     = ct_q[C_PD][15:8];

  p_odd_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i[0] |=> rdata_o == 16'h0000);

  p_vid1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == A_VID1 |=> rdata_o == 16'h414C);

  p_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == A_RESET |=> rdata_o == CAP_WORD);

  p_rd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  p_pd_stat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == CT_ADDR[C_PD] |=> rdata_o[PSW-1:0] == $past(pd_status_i));

  p_pd_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == CT_ADDR[C_PD] |=> pd_req_o == $past(wdata_i[15:8]));
endmodule

// File: tb/tb_mix_regfile.sv
`timescale 1ns/1ps
module tb_mix_regfile;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [15:0] rdata_o;
  logic [3:0]  pd_status_i = '0;
  logic [4:0]  st_mute_o;
  logic [24:0] st_left_o, st_right_o;
  logic [1:0]  mono_mute_o;
  logic [9:0]  mono_vol_o;
  logic [2:0]  rec_sel_l_o, rec_sel_r_o;
  logic        rec_mute_o;
  logic [3:0]  rec_gain_l_o, rec_gain_r_o;
  logic        spatial_en_o;
  logic [1:0]  depth_o;
  logic [7:0]  pd_req_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  mix_regfile dut (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_en_i, .rd_en_i, .rdata_o,
    .pd_status_i, .st_mute_o, .st_left_o, .st_right_o, .mono_mute_o,
    .mono_vol_o, .rec_sel_l_o, .rec_sel_r_o, .rec_mute_o, .rec_gain_l_o,
    .rec_gain_r_o, .spatial_en_o, .depth_o, .pd_req_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  // {req, op(1=write), addr, wdata, expected}
  localparam int NV = 42;
  localparam logic [55:0] VEC [NV] = '{
    {8'd1, 8'd0, 8'h02, 16'h0000, 16'h8000},  // R1
    {8'd1, 8'd0, 8'h10, 16'h0000, 16'h8808},
    {8'd1, 8'd0, 8'h18, 16'h0000, 16'h8808},
    {8'd1, 8'd0, 8'h0C, 16'h0000, 16'h8008},
    {8'd1, 8'd0, 8'h1C, 16'h0000, 16'h8000},
    {8'd5, 8'd0, 8'h00, 16'h0000, 16'h0400},  // R5 capability
    {8'd2, 8'd1, 8'h02, 16'h3F3F, 16'h0000},  // R2 saturation
    {8'd2, 8'd0, 8'h02, 16'h0000, 16'h1F1F},
    {8'd2, 8'd1, 8'h02, 16'hA5A5, 16'h0000},
    {8'd2, 8'd0, 8'h02, 16'h0000, 16'h9F1F},
    {8'd3, 8'd1, 8'h10, 16'h4CC7, 16'h0000},  // R3 reserved bits
    {8'd3, 8'd0, 8'h10, 16'h0000, 16'h0C07},
    {8'd2, 8'd1, 8'h0E, 16'h0025, 16'h0000},
    {8'd2, 8'd0, 8'h0E, 16'h0000, 16'h001F},
    {8'd3, 8'd1, 8'h0C, 16'h8A13, 16'h0000},
    {8'd3, 8'd0, 8'h0C, 16'h0000, 16'h8013},
    {8'd3, 8'd1, 8'h1A, 16'hFFFF, 16'h0000},
    {8'd3, 8'd0, 8'h1A, 16'h0000, 16'h0707},
    {8'd3, 8'd1, 8'h1C, 16'hFFFF, 16'h0000},
    {8'd3, 8'd0, 8'h1C, 16'h0000, 16'h8F0F},
    {8'd3, 8'd1, 8'h20, 16'hFFFF, 16'h0000},
    {8'd3, 8'd0, 8'h20, 16'h0000, 16'h2000},
    {8'd3, 8'd1, 8'h22, 16'hFFFF, 16'h0000},
    {8'd3, 8'd0, 8'h22, 16'h0000, 16'h0003},
    {8'd7, 8'd1, 8'h28, 16'h1234, 16'h0000},  // R7 identity
    {8'd7, 8'd0, 8'h28, 16'h0000, 16'h0600},
    {8'd7, 8'd0, 8'h7C, 16'h0000, 16'h414C},
    {8'd7, 8'd0, 8'h7E, 16'h0000, 16'h4730},
    {8'd6, 8'd1, 8'h03, 16'hFFFF, 16'h0000},  // R6 odd/unmapped
    {8'd6, 8'd0, 8'h02, 16'h0000, 16'h9F1F},
    {8'd6, 8'd0, 8'h03, 16'h0000, 16'h0000},
    {8'd6, 8'd1, 8'h04, 16'hFFFF, 16'h0000},
    {8'd6, 8'd0, 8'h04, 16'h0000, 16'h0000},
    {8'd8, 8'd1, 8'h26, 16'hA5FF, 16'h0000},  // R8 request byte
    {8'd8, 8'd0, 8'h26, 16'h0000, 16'hA500},
    {8'd7, 8'd1, 8'h7C, 16'h0000, 16'h0000},
    {8'd7, 8'd0, 8'h7C, 16'h0000, 16'h414C},
    {8'd5, 8'd1, 8'h00, 16'h0000, 16'h0000},  // R5 soft reset
    {8'd5, 8'd0, 8'h02, 16'h0000, 16'h8000},
    {8'd5, 8'd0, 8'h1A, 16'h0000, 16'h0000},
    {8'd5, 8'd0, 8'h26, 16'h0000, 16'h0000},
    {8'd5, 8'd0, 8'h0C, 16'h0000, 16'h8008}
  };

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state at the outputs
    chk("R1 rdata", {16'h0, rdata_o}, 32'h0);
    chk("R1 st_mute", {27'h0, st_mute_o}, 32'h1F);
    chk("R1 st_left", {7'h0, st_left_o}, {7'h0, 5'h08, 5'h08, 5'h08, 5'h08, 5'h00});
    chk("R1 pd_req", {24'h0, pd_req_o}, 32'h0);
    chk("R1 depth", {30'h0, depth_o}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][47:40] == 8'd1) wr(VEC[v][38:32], VEC[v][31:16]);
      else begin
        rd(VEC[v][38:32], d);
        chk($sformatf("R%0d vec %0d addr %h", VEC[v][55:48], v, VEC[v][38:32]),
            {16'h0, d}, {16'h0, VEC[v][15:0]});
      end
    end

    // R4 hold while idle
    rd(7'h10, d);
    repeat (3) @(negedge clk_i);
    chk("R4 idle hold", {16'h0, rdata_o}, 32'h8808);

    // R8 status nibble
    pd_status_i = 4'hA;
    wr(7'h26, 16'h3C00);
    chk("R8 pd_req", {24'h0, pd_req_o}, 32'h3C);
    rd(7'h26, d);
    chk("R8 status", {16'h0, d}, 32'h3C0A);
    pd_status_i = 4'h0;

    // R9 3D gating
    wr(7'h22, 16'h0002);
    wr(7'h20, 16'h0000);
    chk("R9 off en", {31'h0, spatial_en_o}, 32'h0);
    chk("R9 off depth", {30'h0, depth_o}, 32'h0);
    wr(7'h20, 16'h2000);
    chk("R9 on en", {31'h0, spatial_en_o}, 32'h1);
    chk("R9 on depth", {30'h0, depth_o}, 32'h2);

    // R10 exported fields
    wr(7'h12, 16'h0A15);
    chk("R10 cd left", {27'h0, st_left_o[14:10]}, 32'h0A);
    chk("R10 cd right", {27'h0, st_right_o[14:10]}, 32'h15);
    chk("R10 cd mute", {31'h0, st_mute_o[2]}, 32'h0);
    wr(7'h1A, 16'h0305);
    chk("R10 rsel l", {29'h0, rec_sel_l_o}, 32'h3);
    chk("R10 rsel r", {29'h0, rec_sel_r_o}, 32'h5);
    wr(7'h1C, 16'h0A05);
    chk("R10 rgain", {23'h0, rec_mute_o, rec_gain_l_o, rec_gain_r_o}, 32'h0A5);
    wr(7'h0E, 16'h8010);
    chk("R10 mic", {26'h0, mono_mute_o[1], mono_vol_o[9:5]}, 32'h30);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule